// File: doc/BRIEF.md
# Dual-Channel Serial Converter Output Port

This block is the device-side logic of the serial read-out port of a two-channel, 12-bit sampling converter. A host lowers an active-low chip select and then toggles a serial clock. The block captures both channels' conversion words at the chip-select falling edge. It then shifts each word out on its own serial line: three zeros first, then the 12 result bits with the most significant bit first. While the frame is open, each line has an output enable that shows whether the line is driven or floating. A tracking flag shows when the sample-and-hold has gone back to acquiring the input.

If the host keeps chip select low beyond the first result, the frame grows to 32 serial clocks. Each line then carries the other channel's word after a short gap of zeros. Raising chip select closes the frame at any point. The block runs on a fast system clock. It passes both chip select and the serial clock through two-flop synchronizers and works from the edges it detects. Every serial-clock phase must therefore last at least three system clocks, and the outputs settle three system clocks after an input edge.

Top module: `adc_dual_serial_port`

## Requirements
- R1: Out of reset and whenever no frame is open, both enables are 0, both data outputs are 0, and `tracking` is 1.
- R2: A chip-select falling edge opens a frame. Both enables go to 1, both lines drive 0 as the first bit, and `tracking` drops to 0. Both words are captured at that edge, and later changes on the word inputs do not affect the frame.
- R3: Let p be the number of serial-clock falling edges counted since the frame opened. For p = 0, 1 and 2 both lines drive 0. For p = 3 to 14, line A drives bit (14 − p) of the captured A word, and line B drives the same bit of the captured B word.
- R4: For p = 15 to 18 both lines drive 0. A 16-clock frame therefore shows two zeros after the least significant bit.
- R5: For p = 19 to 30, line A drives bit (30 − p) of the captured B word, and line B drives the same bit of the captured A word. At p = 31 both lines drive 0.
- R6: On the 32nd counted falling edge both enables go to 0 and both data outputs go to 0, even while chip select stays low.
- R7: A chip-select rising edge closes the frame at once. Both enables and both data outputs go to 0, and `tracking` returns to 1.
- R8: `tracking` stays 0 until the first serial-clock rising edge that follows the 13th counted falling edge, and then returns to 1.
- R9: A serial-clock falling edge that arrives in the same cycle as the chip-select falling edge is not counted. The next falling edge counts as p = 1.
- R10: Serial-clock edges while chip select is high leave all outputs at their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Chip select, active low, asynchronous |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| word_a | input | 12 | Channel A conversion result |
| word_b | input | 12 | Channel B conversion result |
| sdo_a | output | 1 | Serial data, line A |
| sdo_a_en | output | 1 | Line A driven (1) or floating (0) |
| sdo_b | output | 1 | Serial data, line B |
| sdo_b_en | output | 1 | Line B driven (1) or floating (0) |
| tracking | output | 1 | 1 while the sample-and-hold acquires the input, 0 while it holds |

## Verification
The block's only hidden state is the edge count, the open-frame flag and the two captured words. If the count slips by one, every result bit shows up one position early or late, so the error appears at the first data bit, p = 3. A wrong open-frame flag shows as an enable that does not drop three system clocks after chip select rises. A stale or mis-captured word shows at the first differing bit of the frame. A tracking flag that flips early or late is visible at the one serial-clock rising edge where it should change.

// File: rtl/adcsp_pkg.sv
// Package: shared defaults for the dual-channel serial output port.
// Assumes: one result width for both channels; frame positions are
// derived in the top module from these values.
package adcsp_pkg;
    parameter int RES_W       = 12;  // result bits per channel
    parameter int LEAD_ZEROS  = 3;   // zeros ahead of the first result
    parameter int TRAIL_ZEROS = 1;   // zeros after the chained result
    parameter int FRAME_EDGES = 32;  // falling edge that floats the lines
    parameter int TRACK_EDGES = 13;  // falling edges before track resumes
    parameter int SYNC_STAGES = 2;   // synchronizer depth
endpackage

// File: rtl/adcsp_edge_sync.sv
// Module: synchronizes one asynchronous input and flags its edges.
// Assumes: the input holds each level for at least STAGES+1 system
// clocks; the edge flags are one system clock wide.
module adcsp_edge_sync #(
    parameter int STAGES = 2,
    parameter bit IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    // Shift register: synchronizer stages plus one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){IDLE}};
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    // Edge flags from the last synchronized stage and its delayed copy.
    always_comb begin
        rise = pipe[STAGES-1] & ~pipe[STAGES];
        fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/adcsp_frame_ctrl.sv
// Module: frame sequencer. It counts serial-clock falling edges,
// captures both words when a frame opens and runs the tracking flag.
// Assumes: cs_fall and cs_rise never arrive in the same cycle. A
// chip-select fall takes priority over a serial-clock fall in the same
// cycle.
module adcsp_frame_ctrl #(
    parameter int RES_W       = 12,
    parameter int CNT_W       = 6,
    parameter int FRAME_EDGES = 32,
    parameter int TRACK_EDGES = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_fall,
    input  logic             sclk_rise,
    input  logic [RES_W-1:0] word_a,
    input  logic [RES_W-1:0] word_b,
    output logic             active,
    output logic [CNT_W-1:0] count,
    output logic             tracking,
    output logic [RES_W-1:0] cap_a,
    output logic [RES_W-1:0] cap_b
);
    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_EDGES);
    localparam logic [CNT_W-1:0] TRACK_CNT = CNT_W'(TRACK_EDGES);

    // Frame state: open, close, count edges, release the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            count    <= '0;
            tracking <= 1'b1;
            cap_a    <= '0;
            cap_b    <= '0;
        end else if (cs_fall) begin
            active   <= 1'b1;
            count    <= '0;
            tracking <= 1'b0;
            cap_a    <= word_a;
            cap_b    <= word_b;
        end else if (cs_rise) begin
            active   <= 1'b0;
            tracking <= 1'b1;
        end else if (active) begin
            if (sclk_fall && count < LAST_CNT) count <= count + 1'b1;
            if (sclk_rise && count >= TRACK_CNT) tracking <= 1'b1;
        end
    end
endmodule

// File: rtl/adcsp_lane.sv
// Module: one serial output line. It maps the edge count to the bit
// driven: zeros, its own word, a zero gap, then the partner word.
// Assumes: count saturates at FRAME_EDGES and the line floats from there.
module adcsp_lane #(
    parameter int RES_W       = 12,
    parameter int CNT_W       = 6,
    parameter int P1_MSB      = 3,
    parameter int P1_LSB      = 14,
    parameter int P2_MSB      = 19,
    parameter int P2_LSB      = 30,
    parameter int FRAME_EDGES = 32
) (
    input  logic             active,
    input  logic [CNT_W-1:0] count,
    input  logic [RES_W-1:0] own_word,
    input  logic [RES_W-1:0] other_word,
    output logic             sdo,
    output logic             sdo_en
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [CNT_W-1:0] off1;
    logic [CNT_W-1:0] off2;
    logic             bit_val;

    // Bit selection by frame position; zero whenever the line floats.
    always_comb begin
        sdo_en  = active && (count < CNT_W'(FRAME_EDGES));
        off1    = CNT_W'(P1_LSB) - count;
        off2    = CNT_W'(P2_LSB) - count;
        bit_val = 1'b0;
        if (count >= CNT_W'(P1_MSB) && count <= CNT_W'(P1_LSB))
            bit_val = own_word[off1[IDX_W-1:0]];
        else if (count >= CNT_W'(P2_MSB) && count <= CNT_W'(P2_LSB))
            bit_val = other_word[off2[IDX_W-1:0]];
        sdo = sdo_en & bit_val;
    end
endmodule

// File: rtl/adc_dual_serial_port.sv
// Module: top of the dual-channel serial output port. It synchronizes
// chip select and the serial clock, sequences the frame and drives two
// lines whose roles swap for the chained second result.
// Assumes: each serial-clock phase spans at least three system clocks.
module adc_dual_serial_port
    import adcsp_pkg::*;
#(
    parameter int W      = RES_W,
    parameter int LEAD   = LEAD_ZEROS,
    parameter int TRAIL  = TRAIL_ZEROS,
    parameter int EDGES  = FRAME_EDGES,
    parameter int TRACK  = TRACK_EDGES,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_in,
    input  logic         sclk_in,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    output logic         sdo_a,
    output logic         sdo_a_en,
    output logic         sdo_b,
    output logic         sdo_b_en,
    output logic         tracking
);
    localparam int CNT_W  = $clog2(EDGES + 1);
    localparam int P1_MSB = LEAD;
    localparam int P1_LSB = LEAD + W - 1;
    localparam int P2_LSB = EDGES - 1 - TRAIL;
    localparam int P2_MSB = P2_LSB - W + 1;
    localparam int LANES  = 2;

    logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
    logic             active;
    logic [CNT_W-1:0] count;
    logic [W-1:0]     cap_a, cap_b;
    logic [W-1:0]     own_w   [LANES];
    logic [W-1:0]     other_w [LANES];
    logic             lane_d  [LANES];
    logic             lane_en [LANES];

    adcsp_edge_sync #(.STAGES(STAGES), .IDLE(1'b1)) cs_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n_in),
        .rise(cs_rise), .fall(cs_fall)
    );

    adcsp_edge_sync #(.STAGES(STAGES), .IDLE(1'b1)) sclk_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(sclk_in),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    adcsp_frame_ctrl #(
        .RES_W(W), .CNT_W(CNT_W), .FRAME_EDGES(EDGES), .TRACK_EDGES(TRACK)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
        .word_a(word_a), .word_b(word_b),
        .active(active), .count(count), .tracking(tracking),
        .cap_a(cap_a), .cap_b(cap_b)
    );

    // Lane word routing: each line chains its partner's word.
    always_comb begin
        own_w[0]   = cap_a;
        other_w[0] = cap_b;
        own_w[1]   = cap_b;
        other_w[1] = cap_a;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adcsp_lane #(
            .RES_W(W), .CNT_W(CNT_W),
            .P1_MSB(P1_MSB), .P1_LSB(P1_LSB),
            .P2_MSB(P2_MSB), .P2_LSB(P2_LSB),
            .FRAME_EDGES(EDGES)
        ) lane_i (
            .active(active), .count(count),
            .own_word(own_w[g]), .other_word(other_w[g]),
            .sdo(lane_d[g]), .sdo_en(lane_en[g])
        );
    end

    // Output mapping from lane array to named ports.
    always_comb begin
        sdo_a    = lane_d[0];
        sdo_a_en = lane_en[0];
        sdo_b    = lane_d[1];
        sdo_b_en = lane_en[1];
    end
endmodule

// File: rtl/adcsp_checker.sv
// Module: port-level properties of the serial output port, attached to
// the top module through bind.
// Assumes: synchronous active-low reset; cs_n_in is high during reset.
module adcsp_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n_in,
    input logic sdo_a,
    input logic sdo_a_en,
    input logic sdo_b,
    input logic sdo_b_en,
    input logic tracking
);
    a_r1_idle_a_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_a_en |-> !sdo_a);
    a_r1_idle_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_b_en |-> !sdo_b);
    a_r1_idle_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_a_en |-> tracking);
    a_r2_open_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_a_en) |-> (!sdo_a && !sdo_b && !tracking));
    a_r6_lanes_agree: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_a_en == sdo_b_en);
    a_r7_cs_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_in && $past(cs_n_in) && $past(cs_n_in, 2) && $past(cs_n_in, 3))
        |-> (!sdo_a_en && !sdo_b_en));
endmodule

bind adc_dual_serial_port adcsp_checker chk_i (.*);

// File: tb/adc_dual_serial_port_tb_top.sv
module adc_dual_serial_port_tb_top;
    localparam int WAIT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_in = 1'b1;
    logic        sclk_in = 1'b1;
    logic [11:0] word_a = '0;
    logic [11:0] word_b = '0;
    logic        sdo_a, sdo_a_en, sdo_b, sdo_b_en, tracking;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    adc_dual_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
        .word_a(word_a), .word_b(word_b),
        .sdo_a(sdo_a), .sdo_a_en(sdo_a_en), .sdo_b(sdo_b), .sdo_b_en(sdo_b_en),
        .tracking(tracking)
    );

    // Expected bit at position p (R3, R4, R5).
    function automatic logic exp_bit(int p, logic [11:0] own, logic [11:0] other);
        if (p >= 3 && p <= 14) return own[14-p];
        if (p >= 19 && p <= 30) return other[30-p];
        return 1'b0;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (WAIT) @(posedge clk);
        #1;
    endtask

    task automatic drive_step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_idle(string req);
        chk(req, "sdo_a_en", sdo_a_en, 1'b0);
        chk(req, "sdo_b_en", sdo_b_en, 1'b0);
        chk(req, "sdo_a", sdo_a, 1'b0);
        chk(req, "sdo_b", sdo_b, 1'b0);
        chk(req, "tracking", tracking, 1'b1);
    endtask

    task automatic check_pos(int p, logic [11:0] a, logic [11:0] b);
        string req;
        logic  en;
        en  = (p < 32);
        req = (p < 15) ? "R3" : (p < 19) ? "R4" : (p < 32) ? "R5" : "R6";
        chk(req, "sdo_a_en", sdo_a_en, en);
        chk(req, "sdo_b_en", sdo_b_en, en);
        chk(req, "sdo_a", sdo_a, en ? exp_bit(p, a, b) : 1'b0);
        chk(req, "sdo_b", sdo_b, en ? exp_bit(p, b, a) : 1'b0);
    endtask

    // One frame with nfalls counted falling edges; coinc puts a serial
    // clock fall on the chip-select fall (R9).
    task automatic run_frame(logic [11:0] a, logic [11:0] b, int nfalls, bit coinc);
        drive_step();
        word_a = a;
        word_b = b;
        cs_n_in = 1'b0;
        if (coinc) sclk_in = 1'b0;
        settle();
        // R2: the inputs change after capture; the frame keeps the old words
        word_a = ~a;
        word_b = ~b;
        chk("R2", "tracking", tracking, 1'b0);
        chk(coinc ? "R9" : "R2", "first sdo_a_en", sdo_a_en, 1'b1);
        check_pos(0, a, b);
        if (coinc) begin
            sclk_in = 1'b1;
            settle();
            chk("R9", "tracking after rise", tracking, 1'b0);
            check_pos(0, a, b);
        end
        for (int k = 1; k <= nfalls; k++) begin
            sclk_in = 1'b0;
            settle();
            check_pos(k > 32 ? 32 : k, a, b);
            chk("R8", "tracking after fall", tracking, k >= 14);
            sclk_in = 1'b1;
            settle();
            chk("R8", "tracking after rise", tracking, k >= 13);
        end
        cs_n_in = 1'b1;
        settle();
        check_idle("R7");
        // R10: serial clock toggles with chip select high
        sclk_in = 1'b0;
        settle();
        check_idle("R10");
        sclk_in = 1'b1;
        settle();
        check_idle("R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        settle();
        check_idle("R1");
        // Directed corner cases
        run_frame(12'hA5C, 12'h3F1, 16, 1'b0);  // R3 R4 16-clock frame
        run_frame(12'h800, 12'h001, 15, 1'b0);  // R3 minimal frame
        run_frame(12'hFFF, 12'h000, 32, 1'b0);  // R5 R6 chained frame
        run_frame(12'h6B2, 12'hD49, 36, 1'b0);  // R6 extra clocks past the end
        run_frame(12'h123, 12'hEDC, 0, 1'b0);   // R7 frame closed at once
        run_frame(12'hC3A, 12'h5A7, 8, 1'b0);   // R7 frame closed early
        run_frame(12'h9E4, 12'h2B8, 20, 1'b1);  // R9 coincident edge
        // Random frames
        for (int i = 0; i < 30; i++) begin
            run_frame(12'($urandom), 12'($urandom), $urandom_range(0, 35),
                      ($urandom_range(0, 3) == 0));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule